// File: doc/BRIEF.md
# Parallel-Prefix Binary Adder

This block adds two unsigned N-bit operands with no carry input and returns an N-bit sum plus a carry-out, all in one combinational path. Every carry comes out of a tree of prefix cells. Each cell merges the group propagate and generate pair of a higher bit segment with the pair of the adjacent lower segment.

A single generator builds one of two networks. The parameter `SPARSE` picks which one.

- **Dense (SPARSE = 0).** Every bit position has its own balanced tree. The depth is log2 N cell levels, and the fan-out of any node is at most two.
- **Sparse (SPARSE = 1).** The tree is built over odd positions only. One extra level then produces the even positions from their odd neighbours below. This costs one more level of depth but uses roughly half the cells.

The block is meant to sit in a datapath wherever a wide, fast add is needed and the logic depth must stay logarithmic in the width.

Top module: `prefix_adder`

## Requirements
- R1: Each bit i forms a leaf pair with propagate = a[i] XOR b[i] and generate = a[i] AND b[i]. Sum bit i is that propagate XOR the carry into bit i. The carry into bit 0 is 0.
- R2: A cell combines a higher segment h and the adjacent lower segment l as P = Ph AND Pl and G = Gh OR (Ph AND Gl). The operands are never swapped, so a carry generated below a propagating run reaches the top of the run.
- R3: No node of the network ever has its group propagate and its group generate both at 1.
- R4: `cout_o` equals the carry out of bit N-1. When every bit position propagates, `cout_o` is 0, because there is no carry input.
- R5: `{cout_o, sum_o}` equals the (N+1)-bit value a_i + b_i for every operand pair.
- R6: With SPARSE = 0, the dense network gives the exact sum for all 65536 operand pairs at N = 8, and for random and corner operands at N = 64.
- R7: With SPARSE = 1, the sparse network gives the exact sum for all 65536 operand pairs at N = 8, and for random and corner operands at N = 64.
- R8: Adding zero leaves the other operand unchanged with `cout_o` = 0. Adding two values with the top bit set and all other bits clear gives sum 0 with `cout_o` = 1.
- R9: A carry created in bit 0 travels the full width: all-ones + 1 gives sum 0 with `cout_o` = 1. Alternating patterns with no overlapping ones (0xAA..AA + 0x55..55) give all-ones with `cout_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First addend |
| b_i | input | N | Second addend |
| sum_o | output | N | Low N bits of a_i + b_i |
| cout_o | output | 1 | Carry out of the most significant bit |

## Verification
The block holds no state, so a wrong node in the prefix network shows up at the ports in the same cycle its operands are applied. A swapped operand order, a wrong span or a missing fill cell damages only the carries that pass through that node. Only operand pairs that create a carry and then propagate it across that exact segment will expose the fault. For this reason, N = 8 is covered exhaustively for both networks. At N = 64, long propagating runs are forced on purpose, because random operands rarely produce them.

// File: rtl/prefix_adder.sv
`timescale 1ns/1ps
module prefix_adder #(
  parameter int N      = 32,
  parameter bit SPARSE = 1'b0
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [N-1:0] sum_o,
  output logic         cout_o
);
  localparam int L  = $clog2(N);
  localparam int LV = L + 1;

  logic [LV:0][N-1:0] pp;
  logic [LV:0][N-1:0] gg;
  logic [N-1:0]       carry;

  assign pp[0] = a_i ^ b_i;
  assign gg[0] = a_i & b_i;

  genvar lv, i;
  generate
    for (lv = 0; lv < L; lv++) begin : g_lvl
      localparam int SP = 1 << lv;
      for (i = 0; i < N; i++) begin : g_bit
        if ((SPARSE && (i % 2 == 0)) || (i < SP)) begin : g_pass
          assign pp[lv+1][i] = pp[lv][i];
          assign gg[lv+1][i] = gg[lv][i];
        end else begin : g_cell
          assign pp[lv+1][i] = pp[lv][i] & pp[lv][i-SP];
          assign gg[lv+1][i] = gg[lv][i] | (pp[lv][i] & gg[lv][i-SP]);
        end
      end
    end
    for (i = 0; i < N; i++) begin : g_fill
      if (SPARSE && (i % 2 == 0) && (i > 0)) begin : g_cell
        assign pp[LV][i] = pp[L][i] & pp[L][i-1];
        assign gg[LV][i] = gg[L][i] | (pp[L][i] & gg[L][i-1]);
      end else begin : g_pass
        assign pp[LV][i] = pp[L][i];
        assign gg[LV][i] = gg[L][i];
      end
    end
  endgenerate

  assign carry  = {gg[LV][N-2:0], 1'b0};
  assign sum_o  = pp[0] ^ carry;
  assign cout_o = gg[LV][N-1];

  logic [N:0] ref_sum;
  assign ref_sum = {1'b0, a_i} + {1'b0, b_i};

  always_comb begin
    assert_exact_sum_R5: assert ({cout_o, sum_o} == ref_sum)
      else $error("sum mismatch");
    assert_full_prop_R4: assert (!(pp[LV][N-1] && cout_o))
      else $error("carry out with full propagate");
    assert_zero_addend_R8: assert (!(b_i == '0) || (sum_o == a_i && !cout_o))
      else $error("adding zero altered operand");
    for (int k = 0; k <= LV; k++) begin
      assert_pg_exclusive_R3: assert ((pp[k] & gg[k]) == '0)
        else $error("propagate and generate both set");
    end
  end
endmodule

// File: tb/sim_prefix_adder.sv
`timescale 1ns/1ps
module sim_prefix_adder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [7:0]  a8 = '0, b8 = '0;
  logic [63:0] a64 = '0, b64 = '0;
  logic [7:0]  s8k, s8h;
  logic [63:0] s64k, s64h;
  logic        c8k, c8h, c64k, c64h;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  prefix_adder #(.N(8),  .SPARSE(1'b0)) u0 (.a_i(a8),  .b_i(b8),  .sum_o(s8k),  .cout_o(c8k));
  prefix_adder #(.N(8),  .SPARSE(1'b1)) u1 (.a_i(a8),  .b_i(b8),  .sum_o(s8h),  .cout_o(c8h));
  prefix_adder #(.N(64), .SPARSE(1'b0)) u2 (.a_i(a64), .b_i(b64), .sum_o(s64k), .cout_o(c64k));
  prefix_adder #(.N(64), .SPARSE(1'b1)) u3 (.a_i(a64), .b_i(b64), .sum_o(s64h), .cout_o(c64h));

  function automatic logic [8:0] exp8(input logic [7:0] x, input logic [7:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction
  function automatic logic [64:0] exp64(input logic [63:0] x, input logic [63:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  task automatic chk8(input string tag);
    logic [8:0] e;
    e = exp8(a8, b8);
    nchk += 2;
    if ({c8k, s8k} !== e) begin
      nfail++;
      $display("FAIL %s dense8 a=%h b=%h got=%h exp=%h", tag, a8, b8, {c8k, s8k}, e);
    end
    if ({c8h, s8h} !== e) begin
      nfail++;
      $display("FAIL %s sparse8 a=%h b=%h got=%h exp=%h", tag, a8, b8, {c8h, s8h}, e);
    end
  endtask

  task automatic chk64(input string tag);
    logic [64:0] e;
    e = exp64(a64, b64);
    nchk += 2;
    if ({c64k, s64k} !== e) begin
      nfail++;
      $display("FAIL %s dense64 a=%h b=%h got=%h exp=%h", tag, a64, b64, {c64k, s64k}, e);
    end
    if ({c64h, s64h} !== e) begin
      nfail++;
      $display("FAIL %s sparse64 a=%h b=%h got=%h exp=%h", tag, a64, b64, {c64h, s64h}, e);
    end
  endtask

  task automatic v64(input logic [63:0] x, input logic [63:0] y, input string tag);
    @(posedge clk);
    a64 = x;
    b64 = y;
    @(negedge clk);
    chk64(tag);
  endtask

  task automatic v8(input logic [7:0] x, input logic [7:0] y, input string tag);
    @(posedge clk);
    a8 = x;
    b8 = y;
    @(negedge clk);
    chk8(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk8("R1 idle zero");
    chk64("R1 idle zero");

    v8(8'hFF, 8'h01, "R9");
    v8(8'h80, 8'h80, "R8");
    v8(8'h5A, 8'h00, "R8");
    v8(8'hAA, 8'h55, "R4");

    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 256; y++)
        v8(x[7:0], y[7:0], "R5 R6 R7 R2 exhaustive");

    v64('0, '0, "R1");
    v64({64{1'b1}}, 64'd1, "R9 full ripple");
    v64(64'd1, {64{1'b1}}, "R2 order");
    v64({64{1'b1}}, {64{1'b1}}, "R5");
    v64({32{2'b10}}, {32{2'b01}}, "R4 R9 no carry");
    v64(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, "R8");
    v64(64'h0123_4567_89AB_CDEF, '0, "R8 zero");
    v64(64'h7FFF_FFFF_FFFF_FFFF, 64'd1, "R3 R2");

    void'($urandom(32'd2024));
    for (int n = 0; n < 15000; n++) begin
      logic [63:0] x, y;
      x = {$urandom, $urandom};
      y = {$urandom, $urandom};
      if (n % 4 == 1) y = ~x;
      if (n % 4 == 2) y = (~x) + 64'd1;
      v64(x, y, "R6 R7 random");
    end
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule